// File: doc/BRIEF.md
# Configurable Mode GPIO Port

An eight-pin general-purpose I/O port in which every pin is set up by three register bits: a direction bit, an option bit and a data bit, read as a three-bit code in that order. Output pins drive their data bit in either open-drain or push-pull form. On an input pin the data bit holds no output value. Together with the option bit, it selects the input features: pull-up, level interrupt, or routing to an analog input.

Software reaches the three per-pin registers and a one-bit interrupt enable through a small register bus. Writes take effect at the clock edge and reads are combinational. A read of the data register returns a per-pin mix: the latch bit for output pins and the live pad level for input pins. An input vector marks pins with no bond wire. Those pins keep their reset configuration and read as zero. A monitor emits a one-cycle error pulse when a single write moves a pin directly between the interrupt mode and the analog mode.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is in code 000 (direction, option, data): padOe is 0, padPullUp is all ones, padAnalog is 0, irqN is 1, the interrupt enable is 0, and the direction and option registers read 0.
- R2: For input codes, padOe and padOut are 0. padPullUp is 1 for codes 000 and 010 and 0 for codes 001 and 011. padAnalog is 1 only for code 011.
- R3: For codes 10x (open drain), padOut equals the data bit and padOe is 1 only when the data bit is 0. Pull-up and analog select are 0.
- R4: For codes 11x (push-pull), padOe is 1 and padOut equals the data bit. Pull-up and analog select are 0.
- R5: Address 0 reads, in the same cycle, the data latch bit for pins whose direction bit is 1 and padIn for pins whose direction bit is 0.
- R6: Address 1 reads the direction register and address 2 reads the option register. Address 3 holds the interrupt enable in bit 0 and reads 0 in bits 7..1. A write to an address changes only that register.
- R7: irqN is 0 exactly when the interrupt enable is 1 and at least one pin in code 010 has padIn low. A pin low in any other code never asserts it.
- R8: Pins flagged in unbondedMask ignore writes. They stay in code 000, drive padOe 0 and padPullUp 1, and read 0 at addresses 0, 1 and 2.
- R9: modeErr is 1 for the one cycle after a write that changes any pin from code 010 to 011 or from 011 to 010. It is 0 after every other write and when no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 data, 1 direction, 2 option, 3 interrupt enable |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data for regAddr |
| padIn | input | 8 | Pad input levels |
| unbondedMask | input | 8 | 1 marks a pin with no bond wire (held static) |
| padOe | output | 8 | Pad output enable |
| padOut | output | 8 | Pad output value |
| padPullUp | output | 8 | Pad pull-up enable |
| padAnalog | output | 8 | Pad analog routing select |
| irqN | output | 1 | Active-low level interrupt request |
| modeErr | output | 1 | One-cycle pulse on a direct interrupt-to-analog mode hop |

## Verification
The pad-control and readback checks rotate the eight codes across the pins, so every pin sees every code and each sweep step holds a mix of input and output pins. Pad input patterns of all zeros, all ones and alternating bits then show whether data readback takes the latch or the pad, and whether a low pin in a code other than 010 leaks into the interrupt. Each interrupt case is tried with the enable set and with it clear, which shows whether the enable gates the request. The transition monitor is tried with direct hops in both directions, with hops routed through another code, and with writes that touch only unbonded pins. These cases separate a real hop from one that is merely adjacent.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrOpt;
    logic wrIntEn;
  } gpioStrobe_t;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_OPT   = 2'd2,
    SEL_INTEN = 2'd3
  } regSel_t;

  localparam logic [2:0] CODE_IN_PU   = 3'b000;
  localparam logic [2:0] CODE_IN_FLT  = 3'b001;
  localparam logic [2:0] CODE_IN_IRQ  = 3'b010;
  localparam logic [2:0] CODE_IN_ANA  = 3'b011;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output gpioStrobe_t       strb,
  output regSel_t           rdSel
);

  always_comb begin
    rdSel = regSel_t'(regAddr[1:0]);
    strb  = '0;
    if (regWe) begin
      unique case (rdSel)
        SEL_DATA:  strb.wrData  = 1'b1;
        SEL_DIR:   strb.wrDir   = 1'b1;
        SEL_OPT:   strb.wrOpt   = 1'b1;
        SEL_INTEN: strb.wrIntEn = 1'b1;
        default:   strb         = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStrobe_t      strb,
  input  regSel_t          rdSel,
  input  logic [WIDTH-1:0] regWdata,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] unbondedMask,
  output logic [WIDTH-1:0] regRdata,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullUp,
  output logic [WIDTH-1:0] padAnalog,
  output logic             irqN,
  output logic             modeErr
);

  logic [WIDTH-1:0] dirQ, optQ, dataQ;
  logic [WIDTH-1:0] dirNxt, optNxt, dataNxt;
  logic [WIDTH-1:0] wrMask;
  logic             intEnQ;
  logic [WIDTH-1:0] irqPin;
  logic [WIDTH-1:0] hopPin;
  logic [WIDTH-1:0] dataView;
  logic             modeErrQ;

  assign wrMask = ~unbondedMask;

  // Next-state values; writes never touch unbonded pins.
  assign dirNxt  = strb.wrDir  ? (regWdata & wrMask) : dirQ;
  assign optNxt  = strb.wrOpt  ? (regWdata & wrMask) : optQ;
  assign dataNxt = strb.wrData ? (regWdata & wrMask) : dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ     <= '0;
      optQ     <= '0;
      dataQ    <= '0;
      intEnQ   <= 1'b0;
      modeErrQ <= 1'b0;
    end else begin
      dirQ     <= dirNxt;
      optQ     <= optNxt;
      dataQ    <= dataNxt;
      if (strb.wrIntEn) intEnQ <= regWdata[0];
      modeErrQ <= |hopPin;
    end
  end

  // Per-pin mode decode.
  for (genvar i = 0; i < WIDTH; i++) begin : gPin
    logic [2:0] codeNow;
    logic [2:0] codeNxt;
    assign codeNow = {dirQ[i], optQ[i], dataQ[i]};
    assign codeNxt = {dirNxt[i], optNxt[i], dataNxt[i]};

    always_comb begin
      padOe[i]     = 1'b0;
      padOut[i]    = 1'b0;
      padPullUp[i] = 1'b0;
      padAnalog[i] = 1'b0;
      irqPin[i]    = 1'b0;
      unique case (codeNow)
        CODE_IN_PU:  padPullUp[i] = 1'b1;
        CODE_IN_FLT: padPullUp[i] = 1'b0;
        CODE_IN_IRQ: begin
          padPullUp[i] = 1'b1;
          irqPin[i]    = ~padIn[i];
        end
        CODE_IN_ANA: padAnalog[i] = 1'b1;
        3'b100, 3'b101: begin
          padOut[i] = dataQ[i];
          padOe[i]  = ~dataQ[i];
        end
        default: begin
          padOut[i] = dataQ[i];
          padOe[i]  = 1'b1;
        end
      endcase
    end

    assign hopPin[i] = ((codeNow == CODE_IN_IRQ) && (codeNxt == CODE_IN_ANA)) ||
                       ((codeNow == CODE_IN_ANA) && (codeNxt == CODE_IN_IRQ));

    assign dataView[i] = wrMask[i] & (dirQ[i] ? dataQ[i] : padIn[i]);
  end

  always_comb begin
    unique case (rdSel)
      SEL_DATA:  regRdata = dataView;
      SEL_DIR:   regRdata = dirQ;
      SEL_OPT:   regRdata = optQ;
      SEL_INTEN: regRdata = {{(WIDTH-1){1'b0}}, intEnQ};
      default:   regRdata = '0;
    endcase
  end

  assign irqN    = ~(intEnQ & (|irqPin));
  assign modeErr = modeErrQ;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  input  logic [WIDTH-1:0]  padIn,
  input  logic [WIDTH-1:0]  unbondedMask,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padPullUp,
  output logic [WIDTH-1:0]  padAnalog,
  output logic              irqN,
  output logic              modeErr
);

  gpioStrobe_t strb;
  regSel_t     rdSel;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWe  (regWe),
    .regAddr(regAddr),
    .strb   (strb),
    .rdSel  (rdSel)
  );

  gpio_port_datapath #(.WIDTH(WIDTH)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rdSel       (rdSel),
    .regWdata    (regWdata),
    .padIn       (padIn),
    .unbondedMask(unbondedMask),
    .regRdata    (regRdata),
    .padOe       (padOe),
    .padOut      (padOut),
    .padPullUp   (padPullUp),
    .padAnalog   (padAnalog),
    .irqN        (irqN),
    .modeErr     (modeErr)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [WIDTH-1:0]  padIn,
  input logic [WIDTH-1:0]  unbondedMask,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padPullUp,
  input logic [WIDTH-1:0]  padAnalog,
  input logic              irqN,
  input logic              modeErr
);

  assert_analog_no_pullup_R2: assert property (@(posedge clk) disable iff (!rstN)
    (padAnalog & padPullUp) == '0);

  assert_analog_not_driven_R2: assert property (@(posedge clk) disable iff (!rstN)
    (padAnalog & padOe) == '0);

  assert_unbonded_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & unbondedMask) == '0);

  assert_irq_needs_low_pin_R7: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> ((~padIn & ~unbondedMask) != '0));

  assert_err_after_data_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> ($past(regWe) && $past(regAddr) == '0));

  assert_err_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (modeErr && !regWe) |=> !modeErr);

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .regWe       (regWe),
  .regAddr     (regAddr),
  .padIn       (padIn),
  .unbondedMask(unbondedMask),
  .padOe       (padOe),
  .padPullUp   (padPullUp),
  .padAnalog   (padAnalog),
  .irqN        (irqN),
  .modeErr     (modeErr)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

  localparam int W = 8;
  localparam logic [W-1:0] UNB = 8'hC0;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWe = 1'b0;
  logic [1:0]   regAddr = '0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic [W-1:0] padIn = '0;
  logic [W-1:0] unbondedMask = UNB;
  logic [W-1:0] padOe, padOut, padPullUp, padAnalog;
  logic         irqN, modeErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model of register contents
  logic [W-1:0] mDir = '0, mOpt = '0, mData = '0;
  logic         mEn  = 1'b0;

  always #5 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn),
    .unbondedMask(unbondedMask), .padOe(padOe), .padOut(padOut),
    .padPullUp(padPullUp), .padAnalog(padAnalog), .irqN(irqN),
    .modeErr(modeErr)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, commit at posedge, return at the following negedge.
  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
    case (a)
      2'd0: mData = d & ~UNB;
      2'd1: mDir  = d & ~UNB;
      2'd2: mOpt  = d & ~UNB;
      default: mEn = d[0];
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  // Expected pad controls from the code table of the requirements.
  task automatic checkPads(input string tag);
    logic [W-1:0] eOe, eOut, ePu, eAna, eRd, v;
    logic eIrq;
    eIrq = 1'b1;
    for (int i = 0; i < W; i++) begin
      eOe[i]  = mDir[i] & (mOpt[i] | ~mData[i]);
      eOut[i] = mDir[i] & mData[i];
      ePu[i]  = ~mDir[i] & ~mData[i];
      eAna[i] = ~mDir[i] & mOpt[i] & mData[i];
      eRd[i]  = UNB[i] ? 1'b0 : (mDir[i] ? mData[i] : padIn[i]);
      if (mEn && !mDir[i] && mOpt[i] && !mData[i] && !padIn[i]) eIrq = 1'b0;
    end
    #1;
    check(padOe === eOe, {tag, " R2/R3/R4 padOe"}, padOe, eOe);
    check(padOut === eOut, {tag, " R3/R4 padOut"}, padOut, eOut);
    check(padPullUp === ePu, {tag, " R2 padPullUp"}, padPullUp, ePu);
    check(padAnalog === eAna, {tag, " R2 padAnalog"}, padAnalog, eAna);
    check(irqN === eIrq, {tag, " R7 irqN"}, {7'd0, irqN}, {7'd0, eIrq});
    rd(2'd0, v);
    check(v === eRd, {tag, " R5 data read"}, v, eRd);
  endtask

  initial begin
    logic [W-1:0] v, d, o, x;
    logic [W-1:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55; pats[3] = 8'hAA;

    repeat (3) @(negedge clk);
    padIn = 8'h5A;
    #1;
    // R1 reset state
    check(padOe === 8'h00, "R1 padOe", padOe, 8'h00);
    check(padPullUp === 8'hFF, "R1 padPullUp", padPullUp, 8'hFF);
    check(padAnalog === 8'h00, "R1 padAnalog", padAnalog, 8'h00);
    check(irqN === 1'b1, "R1 irqN", {7'd0, irqN}, 8'h01);
    rd(2'd1, v); check(v === 8'h00, "R1 dir read", v, 8'h00);
    rd(2'd2, v); check(v === 8'h00, "R1 opt read", v, 8'h00);
    rd(2'd3, v); check(v === 8'h00, "R1 enable read", v, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    checkPads("R1 after release");

    // Rotating code sweep: pin i gets code (i+k) mod 8
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < W; i++) begin
        logic [2:0] c;
        c = 3'((i + k) % 8);
        d[i] = c[2]; o[i] = c[1]; x[i] = c[0];
      end
      wr(2'd1, d); wr(2'd2, o); wr(2'd0, x);
      rd(2'd1, v); check(v === (d & ~UNB), "R6/R8 dir read", v, d & ~UNB);
      rd(2'd2, v); check(v === (o & ~UNB), "R6/R8 opt read", v, o & ~UNB);
      for (int e = 0; e < 2; e++) begin
        wr(2'd3, 8'(e));
        rd(2'd3, v); check(v === 8'(e), "R6 enable read", v, 8'(e));
        for (int p = 0; p < 4; p++) begin
          padIn = pats[p] ^ 8'(k);
          checkPads("sweep");
        end
      end
    end

    // R8: unbonded pins ignore full-width writes
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd0, 8'h00);
    padIn = 8'hFF; #1;
    check((padOe & UNB) === 8'h00, "R8 unbonded oe", padOe & UNB, 8'h00);
    check((padPullUp & UNB) === UNB, "R8 unbonded pullup", padPullUp & UNB, UNB);
    rd(2'd0, v); check((v & UNB) === 8'h00, "R8 unbonded data read", v & UNB, 8'h00);

    // R9: mode hop monitor
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd0, 8'h00);   // all bonded pins in 010
    check(modeErr === 1'b0, "R9 no hop 1xx to 010", {7'd0, modeErr}, 8'h00);
    padIn = 8'hFE; checkPads("R7 one low irq pin");
    wr(2'd0, 8'h01);                                      // pin0 010 -> 011
    check(modeErr === 1'b1, "R9 hop 010->011", {7'd0, modeErr}, 8'h01);
    @(negedge clk);
    check(modeErr === 1'b0, "R9 pulse ends", {7'd0, modeErr}, 8'h00);
    wr(2'd0, 8'h00);                                      // pin0 011 -> 010
    check(modeErr === 1'b1, "R9 hop 011->010", {7'd0, modeErr}, 8'h01);
    wr(2'd0, 8'hC0);                                      // unbonded bits only
    check(modeErr === 1'b0, "R9 unbonded write no hop", {7'd0, modeErr}, 8'h00);
    wr(2'd2, 8'h00);                                      // 010 -> 000
    check(modeErr === 1'b0, "R9 010->000 no hop", {7'd0, modeErr}, 8'h00);
    wr(2'd0, 8'h02); wr(2'd2, 8'h02);                     // pin1 001 -> 011 via option
    check(modeErr === 1'b0, "R9 001->011 no hop", {7'd0, modeErr}, 8'h00);
    wr(2'd0, 8'h00);                                      // pin1 011 -> 010
    check(modeErr === 1'b1, "R9 hop via data", {7'd0, modeErr}, 8'h01);
    padIn = 8'h00; checkPads("R7 final");
    wr(2'd3, 8'h00); checkPads("R7 masked");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule